// File: doc/BRIEF.md
# Segment:Offset Read Bus Controller

This block takes a read request given as a 16-bit segment and a 16-bit offset and turns it into one read on a slow external memory bus. It combines the two halves into a 20-bit physical address: the segment is moved up four bit positions and the offset is added. Any carry past bit 19 is dropped, so the address wraps inside the 1 MB space. Because many segment and offset pairs name the same byte, every such pair drives the same bus address.

A read runs through a fixed sequence of bus cycles. First the address is placed on the bus with the read strobe still high. Then the active-low strobe is pulled low, and it is held low for one further cycle so the memory has time to answer. On the edge where the strobe goes back high, the controller latches the data bus. In the cycle that follows, it raises a one-cycle done pulse and presents the latched word. New requests are accepted only while the controller is idle.

Top module: `seg_read_ctrl`

## Requirements
- R1: The bus address equals (segment × 16 + offset) modulo 2^20. A carry out of bit 19 is discarded, so FFFF:0010 gives 00000.
- R2: Segment and offset pairs that name the same physical byte drive the same bus address. For example, 28F0:0030, 28F3:0000 and 28B0:0430 all give 28F30.
- R3: In the first cycle after a request is accepted, the bus address is valid and busRdN is still high.
- R4: busRdN is low for exactly two consecutive cycles per read: a strobe cycle and a wait cycle. It then returns high.
- R5: rdData takes the value that busData held in the last cycle busRdN was low. It is captured on the edge where busRdN returns high.
- R6: done is high for exactly one cycle, which is the first cycle after busRdN returns high. busy is high from the cycle after acceptance through the wait cycle, and it is low while done is high.
- R7: A request presented while busy is high is ignored. The bus address and the returned data stay those of the read already in progress.
- R8: rdData stays stable from one done pulse until the next done pulse.
- R9: A synchronous reset returns the block to idle. After reset, busRdN is high, busy and done are low, and busAddr and rdData are zero, including when reset arrives in the middle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Read request, taken when idle |
| reqSeg | input | 16 | Segment value of the request |
| reqOff | input | 16 | Offset value of the request |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle pulse: rdData holds a fresh word |
| rdData | output | 16 | Captured read data |
| busAddr | output | 20 | Physical address on the external bus |
| busRdN | output | 1 | Read strobe, active low |
| busData | input | 16 | Data bus driven by the memory |

## Verification
The hardest condition to reach from the ports is a data capture that happens one cycle too early. That capture would still see a plausible word unless the memory withholds valid data. To expose it, the bench memory model drives a junk pattern during the first strobe-low cycle and the real word only in the wait cycle. A second hard case is a request that arrives in the middle of a read. The stimulus drives such a competing request during the address and strobe cycles, then checks that the address and the returned word still belong to the original request.

// File: rtl/seg_read_ctrl_pkg.sv
package seg_read_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_STRB  = 2'd2,
    ST_WAIT  = 2'd3
  } rdState_t;

  typedef struct packed {
    logic loadAddr;
    logic capture;
  } ctlStrb_t;
endpackage

// File: rtl/seg_read_ctrl_path.sv
module seg_read_ctrl_path
  import seg_read_ctrl_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int DATA_W = 16,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrb_t          ctl,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic [DATA_W-1:0] busData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [ADDR_W-1:0] segScaled;
  logic [ADDR_W-1:0] offWide;
  logic [ADDR_W-1:0] physAddr;

  assign segScaled = {reqSeg, {SHIFT{1'b0}}};
  generate
    if (OFF_W >= ADDR_W) begin : g_offTrunc
      assign offWide = reqOff[ADDR_W-1:0];
    end else begin : g_offExt
      assign offWide = {{(ADDR_W-OFF_W){1'b0}}, reqOff};
    end
  endgenerate
  // sum is truncated to ADDR_W bits: carry out of the top bit is dropped
  assign physAddr = segScaled + offWide;

  always_ff @(posedge clk) begin
    if (rst) begin
      busAddr <= '0;
      rdData  <= '0;
    end else begin
      if (ctl.loadAddr) busAddr <= physAddr;
      if (ctl.capture)  rdData  <= busData;
    end
  end
endmodule

// File: rtl/seg_read_ctrl_fsm.sv
module seg_read_ctrl_fsm
  import seg_read_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     reqValid,
  output ctlStrb_t ctl,
  output logic     busy,
  output logic     done,
  output logic     busRdN
);
  rdState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (reqValid) nextState = ST_ADDR;
      ST_ADDR: nextState = ST_STRB;
      ST_STRB: nextState = ST_WAIT;
      ST_WAIT: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.loadAddr = (state == ST_IDLE) && reqValid;
    ctl.capture  = (state == ST_WAIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= ctl.capture;
    end
  end

  assign busy   = (state != ST_IDLE);
  assign busRdN = !((state == ST_STRB) || (state == ST_WAIT));

  // R4
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busRdN) |=> (!busRdN) ##1 busRdN);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  done_on_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busRdN) |-> (done && !busy));
endmodule

// File: rtl/seg_read_ctrl.sv
module seg_read_ctrl
  import seg_read_ctrl_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int DATA_W = 16,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [OFF_W-1:0]  reqOff,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRdN,
  input  logic [DATA_W-1:0] busData
);
  ctlStrb_t ctl;

  seg_read_ctrl_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done),
    .busRdN   (busRdN)
  );

  seg_read_ctrl_path #(
    .SEG_W  (SEG_W),
    .OFF_W  (OFF_W),
    .SHIFT  (SHIFT),
    .DATA_W (DATA_W)
  ) u_path (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .reqSeg  (reqSeg),
    .reqOff  (reqOff),
    .busData (busData),
    .busAddr (busAddr),
    .rdData  (rdData)
  );

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busRdN) |-> $stable(busAddr));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && reqValid) |=> $stable(busAddr));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!done) |-> $stable(rdData));
endmodule

// File: tb/seg_read_ctrl_test.sv
module seg_read_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [15:0] reqSeg = '0;
  logic [15:0] reqOff = '0;
  logic        busy, done, busRdN;
  logic [15:0] rdData, busData;
  logic [19:0] busAddr;

  int checks = 0;
  int errors = 0;
  int lowCnt = 0;

  always #10 clk = ~clk;

  seg_read_ctrl uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqSeg(reqSeg), .reqOff(reqOff),
    .busy(busy), .done(done), .rdData(rdData), .busAddr(busAddr),
    .busRdN(busRdN), .busData(busData)
  );

  // slow memory: junk in the first low cycle, real word from the second
  function automatic logic [15:0] memWord(input logic [19:0] a);
    return a[15:0] ^ {a[19:16], a[19:16], a[19:16], a[19:16]} ^ 16'h3C00;
  endfunction

  always @(posedge clk) lowCnt <= busRdN ? 0 : lowCnt + 1;
  assign busData = (!busRdN && lowCnt >= 1) ? memWord(busAddr) : 16'hDEAD;

  function automatic logic [19:0] expAddr(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] full;
    full = {1'b0, s, 4'h0} + {5'h0, o};
    return full[19:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  localparam int NVEC = 8;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h08F1, 16'h0100}, {16'h028F, 16'h0030},
    {16'h28F0, 16'h0030}, {16'h28F3, 16'h0000},
    {16'h28B0, 16'h0430}, {16'hFFFF, 16'h0010},
    {16'h0000, 16'hFFFF}, {16'hFFFF, 16'hFFFF}
  };

  // one read; if probe is set a competing request is held during the read
  task automatic doRead(input logic [15:0] s, input logic [15:0] o, input bit probe);
    logic [19:0] ea;
    logic [15:0] ed;
    ea = expAddr(s, o);
    ed = memWord(ea);
    @(negedge clk);
    reqValid = 1'b1; reqSeg = s; reqOff = o;
    @(negedge clk);
    if (probe) begin reqSeg = ~s; reqOff = o + 16'h0123; end
    else reqValid = 1'b0;
    check(busAddr == ea, "R1 address", 32'(busAddr), 32'(ea));
    check(busRdN == 1'b1, "R3 strobe high in address cycle", 32'(busRdN), 32'd1);
    check(busy == 1'b1, "R6 busy after accept", 32'(busy), 32'd1);
    @(negedge clk);
    check(busRdN == 1'b0, "R4 strobe low cycle 1", 32'(busRdN), 32'd0);
    @(negedge clk);
    reqValid = 1'b0;
    check(busRdN == 1'b0, "R4 strobe low cycle 2", 32'(busRdN), 32'd0);
    check(busAddr == ea, "R7 address kept during read", 32'(busAddr), 32'(ea));
    check(done == 1'b0, "R6 no early done", 32'(done), 32'd0);
    @(negedge clk);
    check(busRdN == 1'b1, "R4 strobe released", 32'(busRdN), 32'd1);
    check(done == 1'b1 && busy == 1'b0, "R6 done pulse, busy low",
          {30'd0, done, busy}, 32'd2);
    check(rdData == ed, "R5 captured data", 32'(rdData), 32'(ed));
    @(negedge clk);
    check(done == 1'b0, "R6 done single cycle", 32'(done), 32'd0);
    check(busy == 1'b0, "R7 busy request not taken", 32'(busy), 32'd0);
    check(rdData == ed, "R8 data held", 32'(rdData), 32'(ed));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R9 reset state
    check(busRdN == 1'b1 && busy == 1'b0 && done == 1'b0, "R9 reset control",
          {29'd0, busRdN, busy, done}, 32'd4);
    check(busAddr == 20'h0 && rdData == 16'h0, "R9 reset data",
          {12'd0, busAddr}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) doRead(VEC[i][31:16], VEC[i][15:0], 1'b0);

    // R2 aliasing: three pairs naming 28F30
    check(expAddr(16'h28B0, 16'h0430) == 20'h28F30, "R2 alias reference",
          32'(expAddr(16'h28B0, 16'h0430)), 32'h28F30);
    doRead(16'h28F0, 16'h0030, 1'b0);
    check(busAddr == 20'h28F30, "R2 alias 28F0:0030", 32'(busAddr), 32'h28F30);
    doRead(16'h28F3, 16'h0000, 1'b0);
    check(busAddr == 20'h28F30, "R2 alias 28F3:0000", 32'(busAddr), 32'h28F30);
    // R1 wrap past 1 MB
    doRead(16'hFFFF, 16'h0010, 1'b0);
    check(busAddr == 20'h00000, "R1 wrap to zero", 32'(busAddr), 32'h0);

    // R7 competing request during a read
    doRead(16'h1234, 16'h5678, 1'b1);

    // R9 reset in the middle of a read
    @(negedge clk);
    reqValid = 1'b1; reqSeg = 16'h4000; reqOff = 16'h0001;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    check(busRdN == 1'b0, "R4 strobe low before reset", 32'(busRdN), 32'd0);
    rst = 1'b1;
    @(negedge clk);
    check(busRdN == 1'b1 && busy == 1'b0 && done == 1'b0, "R9 mid-read reset control",
          {29'd0, busRdN, busy, done}, 32'd4);
    check(rdData == 16'h0 && busAddr == 20'h0, "R9 mid-read reset data",
          32'(rdData), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && busRdN == 1'b1, "R9 stays idle after reset",
          {30'd0, done, busRdN}, 32'd1);
    doRead(16'h0001, 16'h0002, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule